// File: doc/BRIEF.md
# Control-Transfer Micro-Sequencer

This block carries out the control-transfer instructions of a small 8-bit processor with a 16-bit address space: absolute jump, relative jump, call, return, return-from-interrupt and jump-to-HL. Opcode decode happens elsewhere. The block receives the decoded operation, a condition select, the zero and carry flags and the HL pair. It then reads its immediate bytes from a byte-wide fetch stream, issues stack stores and loads on a byte memory port, and commits the new program counter and stack pointer. `pc_o` holds the address of the byte that follows the opcode. Operand bytes are fetched at `pc_o`, `pc_o+1`.

All three data interfaces use valid/ready. The start port transfers when `start_valid_i` and `start_ready_o` are both high, and `start_ready_o` is high only while the block is idle.

The fetch port runs in the other direction. The block raises `fetch_ready_o` with a stable `fetch_addr_o`, and a byte moves on any cycle in which `fetch_valid_i` is also high. The source may hold `fetch_valid_i` low for any number of cycles.

The memory request port transfers when `mem_valid_o` and `mem_ready_i` are both high. Until then the address, data and write-enable stay unchanged. Each accepted read is answered by exactly one `rd_valid_i` pulse in a later cycle, and the block always accepts that pulse without back-pressure.

Top module: `ctl_xfer_seq`

## Requirements
- R1: After a synchronous active-high reset, `pc_o` and `sp_o` are 0, `done_o` and `ie_set_o` are low, `start_ready_o` is high, and no fetch or memory request is raised.
- R2: `cond_i` selects the condition as follows: 0 always, 1 carry set, 2 zero set, 3 carry clear, 4 zero clear. Codes 5 to 7 are never true. The flags are sampled when the start transfers.
- R3: Op 0 (absolute jump) fetches the low byte and then the high byte. If taken, PC becomes high*256+low. If not taken, PC becomes PC+2.
- R4: Op 1 (relative jump) fetches one byte. If taken, PC becomes PC+1 plus that byte sign-extended, modulo 65536. If not taken, PC becomes PC+1.
- R5: Measured from the start-transfer edge to the edge that raises `done_o`, with no stalls, the latencies are as follows. A taken jump takes 3 cycles and an untaken one 2. A taken relative jump takes 2 and an untaken one 1. A taken call takes 5 and an untaken one 2. Each taken case includes one idle cycle after PC is loaded.
- R6: Op 2 (call) with a false condition fetches both operand bytes, sets PC to PC+2, issues no memory request and leaves SP unchanged.
- R7: A taken call first lowers SP by 2. It then stores the low byte of PC+2 at the new SP and the high byte at SP+1, in that order, and only then fetches the target low and high bytes. PC becomes the target.
- R8: Op 3 (return) with a true condition reads the byte at SP and then the byte at SP+1. PC becomes (second byte)*256 + first byte, SP increases by 2, and `done_o` rises 5 cycles after the start when there are no stalls. With a false condition it makes no access and `done_o` rises the cycle after the start.
- R9: Op 4 (return from interrupt) ignores the condition and always returns. `ie_set_o` is high for exactly the one cycle in which its `done_o` is high, and never otherwise.
- R10: Op 5 loads PC from `hl_i` with no fetch and no memory access, and `done_o` rises the cycle after the start.
- R11: `done_o` is a one-cycle pulse per instruction, and `start_ready_o` stays low from the cycle after an accepted start until `done_o`.
- R12: SP arithmetic wraps modulo 65536, so a call with SP at 0 stores at 0xFFFE and 0xFFFF, and a return from 0xFFFE leaves SP at 0.
- R13: Under any stall pattern on the fetch and memory ports, pending requests hold their address and data until accepted, and the committed PC, SP and access order match the no-stall case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid_i | input | 1 | Instruction start request |
| start_ready_o | output | 1 | Block idle, start accepted |
| op_i | input | 3 | Decoded operation (R3, R4, R6 to R10 encodings) |
| cond_i | input | 3 | Condition select (R2 encoding) |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| hl_i | input | 16 | HL register pair |
| fetch_ready_o | output | 1 | Block wants an immediate byte |
| fetch_valid_i | input | 1 | Fetch byte available |
| fetch_addr_o | output | 16 | Address of the wanted immediate byte |
| fetch_data_i | input | 8 | Immediate byte |
| mem_valid_o | output | 1 | Stack access request |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_we_o | output | 1 | 1 store, 0 load |
| mem_addr_o | output | 16 | Stack address |
| mem_wdata_o | output | 8 | Store data |
| rd_valid_i | input | 1 | Load data return |
| rd_data_i | input | 8 | Load data |
| pc_o | output | 16 | Committed program counter |
| sp_o | output | 16 | Stack pointer |
| done_o | output | 1 | Instruction retired pulse |
| ie_set_o | output | 1 | Interrupt-enable pulse on return from interrupt |

## Verification
The hardest situation to reach from the ports is a return that reads back bytes a call stored across the 16-bit wrap of SP, with stalls landing between the store of one byte and the next. Stimulus gets there by leaving SP at its reset value of zero, so the first call pushes into 0xFFFE and 0xFFFF and the matching return wraps back to zero. A later phase randomly withholds fetch and memory acceptance while a long mixed sequence of taken and untaken transfers runs, and the bench checks every accepted fetch and stack access against a behavioural model of the same instruction.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;

  localparam logic [2:0] XOP_JUMP = 3'd0;
  localparam logic [2:0] XOP_REL  = 3'd1;
  localparam logic [2:0] XOP_CALL = 3'd2;
  localparam logic [2:0] XOP_RET  = 3'd3;
  localparam logic [2:0] XOP_RETI = 3'd4;
  localparam logic [2:0] XOP_JHL  = 3'd5;

  localparam logic [2:0] CND_ALWAYS = 3'd0;
  localparam logic [2:0] CND_CSET   = 3'd1;
  localparam logic [2:0] CND_ZSET   = 3'd2;
  localparam logic [2:0] CND_CCLR   = 3'd3;
  localparam logic [2:0] CND_ZCLR   = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FLO,
    S_FHI,
    S_FREL,
    S_PLO,
    S_PHI,
    S_RLO,
    S_RLO_W,
    S_RHI,
    S_RHI_W,
    S_STALL
  } xfer_state_e;

endpackage

// File: rtl/ctl_xfer_cond.sv
module ctl_xfer_cond
  import ctl_xfer_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic       z_i,
  input  logic       c_i,
  output logic       ok_o
);
  always_comb begin
    case (sel_i)
      CND_ALWAYS: ok_o = 1'b1;
      CND_CSET:   ok_o = c_i;
      CND_ZSET:   ok_o = z_i;
      CND_CCLR:   ok_o = ~c_i;
      CND_ZCLR:   ok_o = ~z_i;
      default:    ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctl_xfer_rel.sv
module ctl_xfer_rel #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] disp_i,
  output logic [AW-1:0] sum_o
);
  localparam int EXT = AW - DW;
  logic [AW-1:0] disp_ext;
  assign disp_ext = {{EXT{disp_i[DW-1]}}, disp_i};
  assign sum_o    = base_i + disp_ext;
endmodule

// File: rtl/ctl_xfer_seq.sv
module ctl_xfer_seq
  import ctl_xfer_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_valid_i,
  output logic          start_ready_o,
  input  logic [2:0]    op_i,
  input  logic [2:0]    cond_i,
  input  logic          flag_z_i,
  input  logic          flag_c_i,
  input  logic [AW-1:0] hl_i,
  output logic          fetch_ready_o,
  input  logic          fetch_valid_i,
  output logic [AW-1:0] fetch_addr_o,
  input  logic [DW-1:0] fetch_data_i,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic          done_o,
  output logic          ie_set_o
);
  localparam logic [AW-1:0] STEP1 = AW'(1);
  localparam logic [AW-1:0] STEP2 = AW'(2);

  xfer_state_e   state_q;
  logic [AW-1:0] pc_q, sp_q, fptr_q, ret_q;
  logic [DW-1:0] lo_q;
  logic [2:0]    op_q;
  logic          take_q, reti_q, done_q, ie_q;

  logic          cond_ok;
  logic [AW-1:0] rel_sum;
  logic [AW-1:0] fptr_nx;

  ctl_xfer_cond u_cond (
    .sel_i (cond_i),
    .z_i   (flag_z_i),
    .c_i   (flag_c_i),
    .ok_o  (cond_ok)
  );

  assign fptr_nx = fptr_q + STEP1;

  ctl_xfer_rel #(.AW(AW), .DW(DW)) u_rel (
    .base_i (fptr_nx),
    .disp_i (fetch_data_i),
    .sum_o  (rel_sum)
  );

  // Port views derived from the state only, never from inputs.
  assign start_ready_o = (state_q == S_IDLE);
  assign fetch_ready_o = (state_q == S_FLO) || (state_q == S_FHI) || (state_q == S_FREL);
  assign fetch_addr_o  = fptr_q;
  assign mem_valid_o   = (state_q == S_PLO) || (state_q == S_PHI) ||
                         (state_q == S_RLO) || (state_q == S_RHI);
  assign mem_we_o      = (state_q == S_PLO) || (state_q == S_PHI);

  always_comb begin
    case (state_q)
      S_PHI, S_RHI: mem_addr_o = sp_q + STEP1;
      default:      mem_addr_o = sp_q;
    endcase
    mem_wdata_o = (state_q == S_PHI) ? ret_q[AW-1:DW] : ret_q[DW-1:0];
  end

  assign pc_o     = pc_q;
  assign sp_o     = sp_q;
  assign done_o   = done_q;
  assign ie_set_o = ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      sp_q    <= '0;
      fptr_q  <= '0;
      ret_q   <= '0;
      lo_q    <= '0;
      op_q    <= XOP_JUMP;
      take_q  <= 1'b0;
      reti_q  <= 1'b0;
      done_q  <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_valid_i) begin
            op_q   <= op_i;
            fptr_q <= pc_q;
            ret_q  <= pc_q + STEP2;
            take_q <= (op_i == XOP_RETI) ? 1'b1 : cond_ok;
            reti_q <= (op_i == XOP_RETI);
            case (op_i)
              XOP_JUMP: state_q <= S_FLO;
              XOP_REL:  state_q <= S_FREL;
              XOP_CALL: begin
                if (cond_ok) begin
                  sp_q    <= sp_q - STEP2;
                  state_q <= S_PLO;
                end else begin
                  state_q <= S_FLO;
                end
              end
              XOP_RET, XOP_RETI: begin
                if (cond_ok || (op_i == XOP_RETI)) begin
                  state_q <= S_RLO;
                end else begin
                  done_q <= 1'b1;
                end
              end
              XOP_JHL: begin
                pc_q   <= hl_i;
                done_q <= 1'b1;
              end
              default: done_q <= 1'b1;
            endcase
          end
        end
        S_PLO: if (mem_ready_i) state_q <= S_PHI;
        S_PHI: if (mem_ready_i) state_q <= S_FLO;
        S_FLO: begin
          if (fetch_valid_i) begin
            lo_q    <= fetch_data_i;
            fptr_q  <= fptr_nx;
            state_q <= S_FHI;
          end
        end
        S_FHI: begin
          if (fetch_valid_i) begin
            fptr_q <= fptr_nx;
            if (take_q) begin
              pc_q    <= {fetch_data_i, lo_q};
              state_q <= S_STALL;
            end else begin
              pc_q    <= fptr_nx;
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        S_FREL: begin
          if (fetch_valid_i) begin
            fptr_q <= fptr_nx;
            if (take_q) begin
              pc_q    <= rel_sum;
              state_q <= S_STALL;
            end else begin
              pc_q    <= fptr_nx;
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        S_RLO: if (mem_ready_i) state_q <= S_RLO_W;
        S_RLO_W: begin
          if (rd_valid_i) begin
            lo_q    <= rd_data_i;
            state_q <= S_RHI;
          end
        end
        S_RHI: if (mem_ready_i) state_q <= S_RHI_W;
        S_RHI_W: begin
          if (rd_valid_i) begin
            pc_q    <= {rd_data_i, lo_q};
            sp_q    <= sp_q + STEP2;
            state_q <= S_STALL;
          end
        end
        S_STALL: begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
          ie_q    <= reti_q;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R13: a stalled stack request keeps its address, data and direction.
  p_mem_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_we_o)));

  // R13: a stalled fetch keeps asking for the same address.
  p_fetch_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (fetch_ready_o && !fetch_valid_i) |=> (fetch_ready_o && $stable(fetch_addr_o)));

  // R9: the interrupt-enable pulse only accompanies a retirement.
  p_ie_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    ie_set_o |-> done_o);

  // R11: while idle no request is outstanding on either port.
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    start_ready_o |-> (!fetch_ready_o && !mem_valid_o));

  // R12: SP only ever moves by two, modulo 65536.
  p_sp_step_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp_o) |-> ((sp_o == $past(sp_o) - STEP2) || (sp_o == $past(sp_o) + STEP2)));

endmodule

// File: tb/sim_ctl_xfer_seq.sv
`timescale 1ns/1ps
module sim_ctl_xfer_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_valid_i = 1'b0;
  logic        start_ready_o;
  logic [2:0]  op_i = '0;
  logic [2:0]  cond_i = '0;
  logic        flag_z_i = 1'b0;
  logic        flag_c_i = 1'b0;
  logic [15:0] hl_i = '0;
  logic        fetch_ready_o;
  logic        fetch_valid_i = 1'b0;
  logic [15:0] fetch_addr_o;
  logic [7:0]  fetch_data_i = '0;
  logic        mem_valid_o;
  logic        mem_ready_i = 1'b0;
  logic        mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        rd_valid_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic [15:0] pc_o, sp_o;
  logic        done_o, ie_set_o;

  always #2.5 clk = ~clk;

  ctl_xfer_seq u0 (.*);

  int    nchecks = 0;
  int    nfail = 0;
  int    cyc = 0;
  bit    bp = 1'b0;
  string cur_tag = "R1";
  logic [7:0] mem [int];
  int    exp_f [$];
  int    exp_m [$];
  bit    pend = 1'b0;
  logic [7:0] pdata = '0;
  int    m_pc = 0;
  int    m_sp = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdmem(input int a);
    return mem.exists(a & 16'hFFFF) ? mem[a & 16'hFFFF] : 8'h00;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // Port model: stalls, unified byte memory and access checking.
  always @(negedge clk) begin
    if (!rst) begin
      rd_valid_i    = pend;
      rd_data_i     = pdata;
      pend          = 1'b0;
      fetch_valid_i = bp ? ($urandom_range(0, 2) != 0) : 1'b1;
      mem_ready_i   = bp ? ($urandom_range(0, 2) != 0) : 1'b1;
      fetch_data_i  = rdmem(fetch_addr_o);
      if (fetch_ready_o && fetch_valid_i) begin
        if (exp_f.size() == 0) chk(1'b0, cur_tag, "unexpected fetch", fetch_addr_o, 0);
        else chk(exp_f.pop_front() == int'(fetch_addr_o), cur_tag, "fetch address", fetch_addr_o, 0);
      end
      if (mem_valid_o && mem_ready_i) begin
        int key;
        key = (int'(mem_we_o) << 24) | (int'(mem_addr_o) << 8) | (mem_we_o ? int'(mem_wdata_o) : 0);
        if (exp_m.size() == 0) chk(1'b0, cur_tag, "unexpected stack access", key, 0);
        else begin
          int e;
          e = exp_m.pop_front();
          chk(e == key, cur_tag, "stack access", key, e);
        end
        if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
        else begin
          pend  = 1'b1;
          pdata = rdmem(mem_addr_o);
        end
      end
    end
  end

  task automatic run_op(input int op, input int cnd, input bit z, input bit c,
                        input int hl, input int b0, input int b1, input string tag);
    bit ok;
    int npc, nsp, lat, cnt;
    bit eie;
    mem[m_pc & 16'hFFFF]       = b0[7:0];
    mem[(m_pc + 1) & 16'hFFFF] = b1[7:0];
    case (cnd)
      0: ok = 1'b1;
      1: ok = c;
      2: ok = z;
      3: ok = !c;
      4: ok = !z;
      default: ok = 1'b0;
    endcase
    if (op == 4) ok = 1'b1;
    npc = m_pc; nsp = m_sp; eie = (op == 4); lat = 0;
    cur_tag = tag;
    case (op)
      0: begin
        exp_f.push_back(m_pc & 16'hFFFF);
        exp_f.push_back((m_pc + 1) & 16'hFFFF);
        npc = ok ? ((b1 & 255) << 8 | (b0 & 255)) : ((m_pc + 2) & 16'hFFFF);
        lat = ok ? 3 : 2;
      end
      1: begin
        exp_f.push_back(m_pc & 16'hFFFF);
        npc = ok ? ((m_pc + 1 + int'($signed(b0[7:0]))) & 16'hFFFF) : ((m_pc + 1) & 16'hFFFF);
        lat = ok ? 2 : 1;
      end
      2: begin
        if (ok) begin
          nsp = (m_sp - 2) & 16'hFFFF;
          exp_m.push_back((1 << 24) | (nsp << 8) | ((m_pc + 2) & 255));
          exp_m.push_back((1 << 24) | (((nsp + 1) & 16'hFFFF) << 8) | (((m_pc + 2) >> 8) & 255));
        end
        exp_f.push_back(m_pc & 16'hFFFF);
        exp_f.push_back((m_pc + 1) & 16'hFFFF);
        npc = ok ? ((b1 & 255) << 8 | (b0 & 255)) : ((m_pc + 2) & 16'hFFFF);
        lat = ok ? 5 : 2;
      end
      3, 4: begin
        if (ok) begin
          exp_m.push_back(m_sp << 8);
          exp_m.push_back(((m_sp + 1) & 16'hFFFF) << 8);
          npc = (int'(rdmem(m_sp + 1)) << 8) | int'(rdmem(m_sp));
          nsp = (m_sp + 2) & 16'hFFFF;
          lat = 5;
        end else lat = 0;
      end
      default: begin
        npc = hl & 16'hFFFF;
        lat = 0;
      end
    endcase
    do @(negedge clk); while (!start_ready_o);
    start_valid_i = 1'b1;
    op_i = op[2:0]; cond_i = cnd[2:0]; flag_z_i = z; flag_c_i = c; hl_i = hl[15:0];
    cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) start_valid_i = 1'b0;
      if (done_o) break;
      chk(!start_ready_o && !ie_set_o, "R11", "ready or ie while busy", start_ready_o, 0);
      if (cnt > 2000) begin
        chk(1'b0, tag, "watchdog: no retirement", cnt, lat);
        break;
      end
    end
    if (!bp) chk(cnt - 1 == lat, (op <= 2) ? "R5" : tag, "latency", cnt - 1, lat);
    chk(int'(pc_o) == npc, tag, "pc", pc_o, npc);
    chk(int'(sp_o) == nsp, (nsp != m_sp) ? "R12" : tag, "sp", sp_o, nsp);
    chk(ie_set_o == eie, "R9", "interrupt enable pulse", ie_set_o, eie);
    chk(exp_f.size() == 0 && exp_m.size() == 0, tag, "missing accesses",
        exp_f.size() + exp_m.size(), 0);
    exp_f.delete(); exp_m.delete();
    @(negedge clk);
    chk(!done_o && !ie_set_o, "R11", "done not a single pulse", done_o, 0);
    m_pc = npc; m_sp = nsp;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pc_o == 16'h0 && sp_o == 16'h0, "R1", "pc/sp after reset", {pc_o, sp_o}, 0);
    chk(!done_o && !ie_set_o && start_ready_o, "R1", "control after reset", {done_o, ie_set_o, start_ready_o}, 1);
    chk(!fetch_ready_o && !mem_valid_o, "R1", "requests after reset", {fetch_ready_o, mem_valid_o}, 0);

    run_op(5, 0, 0, 0, 16'h1230, 8'hAA, 8'hBB, "R10");
    run_op(0, 0, 0, 0, 0, 8'h78, 8'h56, "R3");
    run_op(0, 1, 0, 0, 0, 8'h11, 8'h22, "R2");
    run_op(1, 2, 1, 0, 0, 8'hF0, 8'h00, "R4");
    run_op(1, 4, 1, 0, 0, 8'h33, 8'h00, "R2");
    run_op(1, 3, 0, 0, 0, 8'h7F, 8'h00, "R4");
    run_op(2, 0, 0, 0, 0, 8'h00, 8'h40, "R7");
    run_op(2, 3, 0, 1, 0, 8'h55, 8'h66, "R6");
    run_op(3, 2, 0, 0, 0, 8'h00, 8'h00, "R8");
    run_op(3, 0, 0, 0, 0, 8'h00, 8'h00, "R8");
    run_op(0, 5, 1, 1, 0, 8'h01, 8'h02, "R2");
    run_op(0, 7, 1, 1, 0, 8'h01, 8'h02, "R2");
    run_op(2, 2, 1, 0, 0, 8'h20, 8'h80, "R7");
    run_op(4, 4, 1, 0, 0, 8'h00, 8'h00, "R9");

    bp = 1'b1;
    for (int i = 0; i < 60; i++) begin
      int op;
      op = $urandom_range(0, 5);
      run_op(op, $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             $urandom_range(0, 16'hFFFF), $urandom_range(0, 255), $urandom_range(0, 255), "R13");
    end
    bp = 1'b0;
    summary();
  end
endmodule